// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control unit and register datapath of a small accumulator machine that runs one instruction at a time. It keeps a program counter, an instruction register, a memory address register, a memory buffer register, an accumulator and a status word. It steps through fetch, an optional indirect subcycle, execute, a one-cycle interrupt check and interrupt entry. All memory traffic goes through one synchronous single-ported interface with a ready handshake.

Every word crosses the memory buffer register, and the address bus is always driven by the memory address register. In a fetch, the program counter goes to the address register, the returned word lands in the buffer register, and from there it moves to the instruction register. The program counter advances by one when the fetch read completes. An indirect operand takes one extra read: it reloads the address register from the low address bits of the returned word. Interrupt entry works as follows. The program counter is routed through the buffer register and written to a fixed save address. The handler address is then loaded into the program counter. A halt instruction parks the sequencer until reset.

Top module: `icyc_sequencer`

## Requirements
- R1: Reset clears the program counter, instruction, address, buffer and accumulator registers and every status bit, and drops both requests. The first read after reset is from address 0.
- R2: Each instruction is fetched with one read at the program counter, which then advances by one. The word is decoded as follows: bits 15:12 are the opcode, bit 11 is the indirect flag and bits 10:0 are the address field. Opcodes: 1 load, 2 store, 3 add, 4 jump, 5 jump-if-zero, 6 enable interrupts, 15 halt. Any other opcode has no effect.
- R3: Load copies the word at the effective address into the accumulator. Store writes the accumulator to the effective address.
- R4: With the indirect flag set, the effective address is the low 11 bits of the word stored at the address field. Any upper bits of that word are ignored.
- R5: Add sums the accumulator and the operand word modulo 2^16. Status bits: bit 0 zero (result is 0), bit 1 carry (carry out of bit 15), bit 2 sign (result bit 15), bit 3 overflow (the operands have equal sign bits and the result sign differs), bit 4 interrupt enable, bit 5 supervisor.
- R6: Only add changes status bits 3:0. Load, store, jumps and other opcodes leave them unchanged.
- R7: Jump loads the program counter with the effective address. Jump-if-zero does the same only when the zero bit is set, and otherwise falls through.
- R8: A read or write request stays high, with address and write data unchanged, until ready is seen. Read and write requests are never high together.
- R9: After an instruction completes, if interrupts are enabled and irq is high, the sequencer writes the program counter (the address of the next instruction) to SAVE_ADDR. It then clears interrupt enable, sets supervisor and fetches next from HANDLER_ADDR.
- R10: While interrupt enable is clear, irq has no effect.
- R11: Halt raises halted, which stays high with no further memory request until reset, even with interrupts enabled and irq high.
- R12: Enable-interrupts sets the enable bit, and the interrupt check that follows that same instruction already sees it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | ADDR_W | Memory address, driven by the address register |
| mem_wdata | output | DATA_W | Write data, driven by the buffer register |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| mem_rd | output | 1 | Read request, held until mem_ready |
| mem_wr | output | 1 | Write request, held until mem_ready |
| mem_ready | input | 1 | Access complete, one cycle per request |
| status | output | 6 | Status word: zero, carry, sign, overflow, interrupt enable, supervisor |
| halted | output | 1 | Sequencer parked by a halt instruction |

## Verification
The coincidence that matters is an interrupt request landing while an instruction is still finishing: either a store whose write is in flight, or a halt being executed with interrupts enabled. The bench raises irq the moment it sees the fetch of a chosen address. It then judges the memory image. The store must have landed, and the saved word must point past it. Under a halt, no save write may appear, the enable bit must remain set and the sequencer must stay parked. A request held over random memory latencies is also checked for stable address and data.

// File: rtl/icyc_pkg.sv
`timescale 1ns/1ps
package icyc_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [3:0] {
    SQ_FETCH,
    SQ_FWAIT,
    SQ_DECODE,
    SQ_IWAIT,
    SQ_EXEC,
    SQ_EWAIT,
    SQ_ICHK,
    SQ_ISAVE,
    SQ_IWRT,
    SQ_HALT
  } sq_state_e;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_JMP   = 4'h4,
    OP_JZ    = 4'h5,
    OP_EI    = 4'h6,
    OP_HALT  = 4'hF
  } opcode_e;

  typedef struct packed {
    logic sup;
    logic ie;
    logic ovf;
    logic neg;
    logic cry;
    logic zer;
  } status_t;

  localparam int STAT_W = $bits(status_t);

  // Opcodes that carry a memory address field
  function automatic logic uses_operand(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) ||
           (op == OP_JMP)  || (op == OP_JZ);
  endfunction
endpackage

// File: rtl/icyc_alu.sv
`timescale 1ns/1ps
module icyc_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              zer_o,
  output logic              cry_o,
  output logic              neg_o,
  output logic              ovf_o
);
  logic [DATA_W:0] wide;

  always_comb begin
    wide  = {1'b0, acc_i} + {1'b0, opnd_i};
    sum_o = wide[DATA_W-1:0];
    zer_o = (wide[DATA_W-1:0] == '0);
    cry_o = wide[DATA_W];
    neg_o = wide[DATA_W-1];
    ovf_o = (acc_i[DATA_W-1] == opnd_i[DATA_W-1]) &&
            (wide[DATA_W-1] != acc_i[DATA_W-1]);
  end
endmodule

// File: rtl/icyc_ctrl.sv
`timescale 1ns/1ps
module icyc_ctrl
  import icyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] fetched_op,
  input  logic             fetched_ind,
  input  logic [OPC_W-1:0] exec_op,
  input  logic             mem_ready,
  input  logic             int_en,
  input  logic             irq,
  output sq_state_e        state_q,
  output sq_state_e        state_d
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_FETCH:  state_d = SQ_FWAIT;
      SQ_FWAIT:  if (mem_ready) state_d = SQ_DECODE;
      SQ_DECODE: state_d = (fetched_ind && uses_operand(fetched_op)) ? SQ_IWAIT : SQ_EXEC;
      SQ_IWAIT:  if (mem_ready) state_d = SQ_EXEC;
      SQ_EXEC: begin
        case (exec_op)
          OP_LOAD, OP_STORE, OP_ADD: state_d = SQ_EWAIT;
          OP_HALT:                   state_d = SQ_HALT;
          default:                   state_d = SQ_ICHK;
        endcase
      end
      SQ_EWAIT:  if (mem_ready) state_d = SQ_ICHK;
      SQ_ICHK:   state_d = (int_en && irq) ? SQ_ISAVE : SQ_FETCH;
      SQ_ISAVE:  state_d = SQ_IWRT;
      SQ_IWRT:   if (mem_ready) state_d = SQ_FETCH;
      SQ_HALT:   state_d = SQ_HALT;
      default:   state_d = SQ_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_FETCH;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/icyc_memreq.sv
`timescale 1ns/1ps
module icyc_memreq (
  input  logic clk,
  input  logic rst,
  input  logic start_rd,
  input  logic start_wr,
  input  logic mem_ready,
  output logic rd_q,
  output logic wr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else if ((rd_q || wr_q) && mem_ready) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else if (start_rd) begin
      rd_q <= 1'b1;
    end else if (start_wr) begin
      wr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/icyc_sequencer.sv
`timescale 1ns/1ps
module icyc_sequencer
  import icyc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 11,
  parameter int SAVE_ADDR    = 2040,
  parameter int HANDLER_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic              mem_ready,
  output logic [STAT_W-1:0] status,
  output logic              halted
);
  localparam int IND_BIT = ADDR_W;
  localparam int OPC_MSB = DATA_W - 1;
  localparam int PAD_W   = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] HAND_A = ADDR_W'(HANDLER_ADDR);

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] ir, mbr, acc;
  status_t           st;
  logic              halted_q;

  sq_state_e         state_q, state_d;
  logic [OPC_W-1:0]  fetched_op, exec_op;
  logic              fetched_ind;
  logic              start_rd, start_wr;
  logic              rd_q, wr_q;

  logic [DATA_W-1:0] alu_sum;
  logic              alu_zer, alu_cry, alu_neg, alu_ovf;
  logic              unused_ir;

  assign fetched_op  = mbr[OPC_MSB -: OPC_W];
  assign fetched_ind = mbr[IND_BIT];
  assign exec_op     = ir[OPC_MSB -: OPC_W];
  assign unused_ir   = ^ir[IND_BIT:0];

  icyc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fetched_op (fetched_op),
    .fetched_ind(fetched_ind),
    .exec_op    (exec_op),
    .mem_ready  (mem_ready),
    .int_en     (st.ie),
    .irq        (irq),
    .state_q    (state_q),
    .state_d    (state_d)
  );

  icyc_alu #(.DATA_W(DATA_W)) u_alu (
    .acc_i (acc),
    .opnd_i(mem_rdata),
    .sum_o (alu_sum),
    .zer_o (alu_zer),
    .cry_o (alu_cry),
    .neg_o (alu_neg),
    .ovf_o (alu_ovf)
  );

  // Request starts: fetch, indirect pointer read, operand read/write, PC save
  always_comb begin
    start_rd = (state_q == SQ_FETCH) ||
               (state_q == SQ_DECODE && state_d == SQ_IWAIT) ||
               (state_q == SQ_EXEC && (exec_op == OP_LOAD || exec_op == OP_ADD));
    start_wr = (state_q == SQ_EXEC && exec_op == OP_STORE) ||
               (state_q == SQ_ISAVE);
  end

  icyc_memreq u_memreq (
    .clk      (clk),
    .rst      (rst),
    .start_rd (start_rd),
    .start_wr (start_wr),
    .mem_ready(mem_ready),
    .rd_q     (rd_q),
    .wr_q     (wr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      mar      <= '0;
      ir       <= '0;
      mbr      <= '0;
      acc      <= '0;
      st       <= '0;
      halted_q <= 1'b0;
    end else begin
      halted_q <= (state_d == SQ_HALT);
      case (state_q)
        SQ_FETCH: mar <= pc;
        SQ_FWAIT: begin
          if (mem_ready) begin
            mbr <= mem_rdata;
            pc  <= pc + 1'b1;
          end
        end
        SQ_DECODE: begin
          ir  <= mbr;
          mar <= mbr[ADDR_W-1:0];
        end
        SQ_IWAIT: begin
          if (mem_ready) begin
            mbr <= mem_rdata;
            mar <= mem_rdata[ADDR_W-1:0];
          end
        end
        SQ_EXEC: begin
          case (exec_op)
            OP_STORE: mbr <= acc;
            OP_JMP:   pc <= mar;
            OP_JZ:    if (st.zer) pc <= mar;
            OP_EI:    st.ie <= 1'b1;
            default:  ;
          endcase
        end
        SQ_EWAIT: begin
          if (mem_ready && exec_op != OP_STORE) begin
            mbr <= mem_rdata;
            if (exec_op == OP_ADD) begin
              acc    <= alu_sum;
              st.zer <= alu_zer;
              st.cry <= alu_cry;
              st.neg <= alu_neg;
              st.ovf <= alu_ovf;
            end else begin
              acc <= mem_rdata;
            end
          end
        end
        SQ_ISAVE: begin
          mbr    <= {{PAD_W{1'b0}}, pc};
          mar    <= SAVE_A;
          st.ie  <= 1'b0;
          st.sup <= 1'b1;
        end
        SQ_IWRT: if (mem_ready) pc <= HAND_A;
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = rd_q;
  assign mem_wr    = wr_q;
  assign status    = st;
  assign halted    = halted_q;
endmodule

// File: rtl/icyc_chk.sv
`timescale 1ns/1ps
module icyc_chk #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 11,
  parameter int SAVE_ADDR = 2040
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [5:0]        status,
  input logic              halted
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == 6'd0) && !mem_rd && !mem_wr && (mem_addr == '0));

  // R8
  no_dual_req_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_ready) |=>
      ((mem_rd || mem_wr) && $stable(mem_addr) && $stable(mem_wdata)));

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status[3:0]) |-> $past(mem_ready && mem_rd));

  // R9
  int_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status[4]) |-> (mem_wr && mem_addr == ADDR_W'(SAVE_ADDR)));

  // R11
  halt_park_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_rd && !mem_wr));
endmodule

bind icyc_sequencer icyc_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .SAVE_ADDR(SAVE_ADDR)
) i_icyc_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_ready(mem_ready),
  .status   (status),
  .halted   (halted)
);

// File: tb/test_icyc_sequencer.sv
`timescale 1ns/1ps
module test_icyc_sequencer;
  localparam int DW = 16;
  localparam int AW = 11;
  localparam int SAVE = 2040;
  localparam int HAND = 64;
  localparam logic [DW-1:0] SENT = 16'hDEAD;
  localparam int C_LOAD = 1, C_STORE = 2, C_ADD = 3, C_JMP = 4, C_JZ = 5, C_EI = 6, C_HALT = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          mem_rd, mem_wr;
  logic          mem_ready;
  logic [5:0]    status;
  logic          halted;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int checks = 0, fails = 0, cyc = 0;
  int lat_max = 0, irq_trig = -1, wait_cnt = 0;
  int dual_cnt = 0, halt_req_cnt = 0;
  int seed_val;

  always #2.5 clk = ~clk;

  icyc_sequencer #(.DATA_W(DW), .ADDR_W(AW), .SAVE_ADDR(SAVE), .HANDLER_ADDR(HAND))
  i_icyc_sequencer (
    .clk(clk), .rst(rst), .irq(irq),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
    .status(status), .halted(halted)
  );

  function automatic logic [DW-1:0] enc(input int op, input bit ind, input int a);
    logic [3:0]    o = op[3:0];
    logic [AW-1:0] f = a[AW-1:0];
    return {o, ind, f};
  endfunction

  // {ovf, sign, carry, zero}
  function automatic logic [3:0] exp_flags(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] w = {1'b0, a} + {1'b0, b};
    return {(a[DW-1] == b[DW-1]) && (w[DW-1] != a[DW-1]), w[DW-1], w[DW], w[DW-1:0] == '0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    mem[SAVE] = SENT;
  endtask

  task automatic put_handler();
    mem[HAND]     = enc(C_LOAD, 0, 102);
    mem[HAND + 1] = enc(C_STORE, 0, 103);
    mem[HAND + 2] = enc(C_HALT, 0, 0);
  endtask

  task automatic run_prog(input bit first_chk);
    int n;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    if (first_chk) begin
      chk("R1 requests in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
      chk("R1 status in reset", {26'd0, status}, 32'd0);
      chk("R1 halted in reset", {31'd0, halted}, 32'd0);
      chk("R1 address in reset", {21'd0, mem_addr}, 32'd0);
    end
    rst = 1'b0;
    if (first_chk) begin
      n = 0;
      while (!mem_rd && n < 20) begin @(negedge clk); n++; end
      chk("R1 first fetch address", {21'd0, mem_addr}, 32'd0);
    end
    n = 0;
    while (!halted && n < 5000) begin @(negedge clk); n++; end
    if (!halted) begin
      checks++;
      fails++;
      $display("FAIL R11: halt not reached, actual 0 expected 1");
    end
  endtask

  // Memory model with random ready latency; also raises irq on a chosen fetch
  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (irq_trig >= 0 && mem_rd && int'(mem_addr) == irq_trig) irq <= 1'b1;
      if (mem_ready) begin
        mem_ready <= 1'b0;
      end else if (mem_rd || mem_wr) begin
        if (wait_cnt == 0) begin
          mem_ready <= 1'b1;
          mem_rdata <= mem[mem_addr];
          if (mem_wr) mem[mem_addr] <= mem_wdata;
          wait_cnt <= $urandom_range(lat_max, 0);
        end else begin
          wait_cnt <= wait_cnt - 1;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd && mem_wr) dual_cnt++;
      if (halted && (mem_rd || mem_wr)) halt_req_cnt++;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    seed_val = $urandom(32'h1C4E);

    // R1 R2 R3 R6: reset, load/store, unknown opcode is a no-op
    clear_mem();
    mem[0] = enc(C_LOAD, 0, 100);
    mem[1] = enc(C_STORE, 0, 101);
    mem[2] = enc(7, 0, 101);
    mem[3] = enc(C_STORE, 0, 102);
    mem[4] = enc(C_HALT, 0, 0);
    mem[100] = 16'h1234; mem[101] = SENT; mem[102] = SENT;
    run_prog(1);
    chk("R3 store after load", {16'd0, mem[101]}, 32'h1234);
    chk("R2 unknown opcode leaves acc", {16'd0, mem[102]}, 32'h1234);
    chk("R6 load leaves flags", {26'd0, status}, 32'd0);

    // R5: add with directed corners then random operands
    for (int k = 0; k < 24; k++) begin
      logic [DW-1:0] a, b;
      case (k)
        0: begin a = 16'hFFFF; b = 16'h0001; end
        1: begin a = 16'h7FFF; b = 16'h0001; end
        2: begin a = 16'h8000; b = 16'h8000; end
        3: begin a = 16'h0000; b = 16'h0000; end
        default: begin a = DW'($urandom); b = DW'($urandom); end
      endcase
      lat_max = k % 4;
      clear_mem();
      mem[0] = enc(C_LOAD, 0, 100);
      mem[1] = enc(C_ADD, 0, 101);
      mem[2] = enc(C_STORE, 0, 102);
      mem[3] = enc(C_HALT, 0, 0);
      mem[100] = a; mem[101] = b; mem[102] = SENT;
      run_prog(0);
      chk("R5 sum", {16'd0, mem[102]}, {16'd0, a + b});
      chk("R5 flags", {26'd0, status}, {28'd0, exp_flags(a, b)});
    end

    // R7: jump-if-zero taken only on zero result
    for (int k = 0; k < 8; k++) begin
      logic [DW-1:0] a, b, s;
      a = DW'($urandom);
      b = (k % 2 == 0) ? (~a + 1'b1) : DW'($urandom);
      s = a + b;
      lat_max = 2;
      clear_mem();
      mem[0] = enc(C_LOAD, 0, 100);
      mem[1] = enc(C_ADD, 0, 101);
      mem[2] = enc(C_JZ, 0, 6);
      mem[3] = enc(C_LOAD, 0, 102);
      mem[4] = enc(C_STORE, 0, 103);
      mem[5] = enc(C_HALT, 0, 0);
      mem[6] = enc(C_HALT, 0, 0);
      mem[100] = a; mem[101] = b; mem[102] = 16'h4C4C; mem[103] = SENT;
      run_prog(0);
      chk("R7 jump-if-zero", {16'd0, mem[103]}, {16'd0, (s == '0) ? SENT : 16'h4C4C});
    end

    // R6: loading zero does not set the zero bit, so the branch falls through
    clear_mem();
    mem[0] = enc(C_LOAD, 0, 100);
    mem[1] = enc(C_JZ, 0, 4);
    mem[2] = enc(C_STORE, 0, 101);
    mem[3] = enc(C_HALT, 0, 0);
    mem[4] = enc(C_HALT, 0, 0);
    mem[100] = 16'h0000; mem[101] = SENT;
    run_prog(0);
    chk("R6 load of zero keeps zero bit clear", {16'd0, mem[101]}, 32'd0);

    // R4 R7: indirect jump and indirect load/store, upper pointer bits ignored, long latency
    lat_max = 9;
    clear_mem();
    mem[0] = enc(C_JMP, 1, 50);
    mem[1] = enc(C_STORE, 0, 400);
    mem[2] = enc(C_HALT, 0, 0);
    mem[8] = enc(C_LOAD, 1, 60);
    mem[9] = enc(C_STORE, 1, 61);
    mem[10] = enc(C_HALT, 0, 0);
    mem[50] = 16'hF808;
    mem[60] = 16'hA000 | 16'd300;
    mem[61] = 16'h5800 | 16'd301;
    mem[300] = 16'hBEEF; mem[301] = SENT; mem[400] = SENT;
    run_prog(0);
    chk("R7 jump skips fall-through", {16'd0, mem[400]}, {16'd0, SENT});
    chk("R4 indirect load/store", {16'd0, mem[301]}, 32'hBEEF);
    lat_max = 3;

    // R10: irq with enable clear has no effect
    clear_mem(); put_handler();
    mem[0] = enc(C_LOAD, 0, 100);
    mem[1] = enc(C_STORE, 0, 101);
    mem[2] = enc(C_HALT, 0, 0);
    mem[100] = 16'h0F0F; mem[101] = SENT; mem[102] = 16'h5A5A; mem[103] = SENT;
    irq = 1'b1; irq_trig = -1;
    run_prog(0);
    chk("R10 program ran", {16'd0, mem[101]}, 32'h0F0F);
    chk("R10 no save write", {16'd0, mem[SAVE]}, {16'd0, SENT});
    chk("R10 status", {26'd0, status}, 32'd0);

    // R12 R9: enable with irq already pending enters right after the enable instruction
    clear_mem(); put_handler();
    mem[0] = enc(C_EI, 0, 0);
    mem[1] = enc(C_LOAD, 0, 100);
    mem[2] = enc(C_STORE, 0, 101);
    mem[3] = enc(C_HALT, 0, 0);
    mem[100] = 16'h0F0F; mem[101] = SENT; mem[102] = 16'h5A5A; mem[103] = SENT;
    irq = 1'b1; irq_trig = -1;
    run_prog(0);
    chk("R12 saved pc after enable", {16'd0, mem[SAVE]}, 32'd1);
    chk("R9 interrupted code skipped", {16'd0, mem[101]}, {16'd0, SENT});
    chk("R9 handler ran", {16'd0, mem[103]}, 32'h5A5A);
    chk("R9 status enable clear, supervisor set", {26'd0, status}, 32'h20);

    // R9: irq raised while a store is in flight; store lands, saved pc is past it
    clear_mem(); put_handler();
    mem[0] = enc(C_EI, 0, 0);
    mem[1] = enc(C_LOAD, 0, 100);
    mem[2] = enc(C_STORE, 0, 101);
    mem[3] = enc(C_HALT, 0, 0);
    mem[100] = 16'h3C3C; mem[101] = SENT; mem[102] = 16'h7E7E; mem[103] = SENT;
    irq = 1'b0; irq_trig = 2;
    run_prog(0);
    chk("R9 store completed", {16'd0, mem[101]}, 32'h3C3C);
    chk("R9 saved pc past store", {16'd0, mem[SAVE]}, 32'd3);
    chk("R9 handler after store", {16'd0, mem[103]}, 32'h7E7E);

    // R11: irq arrives during halt with enable set; halt wins and stays parked
    clear_mem(); put_handler();
    mem[0] = enc(C_EI, 0, 0);
    mem[1] = enc(C_HALT, 0, 0);
    mem[103] = SENT;
    irq = 1'b0; irq_trig = 1;
    run_prog(0);
    repeat (40) @(negedge clk);
    chk("R11 still halted", {31'd0, halted}, 32'd1);
    chk("R11 no request while halted", halt_req_cnt, 0);
    chk("R11 no save write", {16'd0, mem[SAVE]}, {16'd0, SENT});
    chk("R11 enable kept", {26'd0, status}, 32'h10);
    irq_trig = -1; irq = 1'b0;

    // R8: never both requests
    chk("R8 dual request cycles", dual_cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule